// File: doc/BRIEF.md
# Power-Up Strap Capture and Pin Turnaround

This block manages six shared pins. At power-up they are configuration inputs, and once the device is running they become clock outputs. After reset is released, a power-on timer counts a set number of system-clock cycles. During that interval every pin output enable stays low, so each pin floats at the level of its external strapping resistor. The sampled levels are copied into hold registers on every cycle of the interval. On the cycle the timer expires, the hold registers freeze and the pin drivers are switched on. The captured values are then kept until the next reset.

Five of the captured bits form a 5-bit frequency select code. A register-supplied code can replace the strapped one when an override bit is set. The block outputs:
- the active code;
- a flag that shows whether the selected frequency combination uses spread-spectrum modulation;
- the choice of the super I/O clock (24 MHz or 48 MHz), taken from the sixth strap.

A test-mode bit forces all clock drivers to high impedance. Frequency synthesis is done elsewhere. This block only supplies the control word and the enables.

Top module: `strap_turnaround`

## Requirements
- R1: While reset is asserted, and from reset release until the timer expires, `pin_oe` is all zeros and `clk_drive_en` is 0.
- R2: The timer expires at the TURN_CYCLES-th rising clock edge after reset is released. From that edge onward, `pin_oe` is all ones and `clk_drive_en` is 1, unless test mode is active.
- R3: The captured strap word equals `pin_lvl` as sampled at the edge where the timer expires. Earlier values are overwritten, and any change on `pin_lvl` after expiry has no effect on `active_sel` or `sio_24m`.
- R4: The straps are sampled again only after a new reset. A second reset clears the capture to zero and then captures the new pin levels.
- R5: With `sel_override` = 0, `active_sel` equals the strapped code, with `pin_lvl[i]` giving select bit i for i = 0..4.
- R6: With `sel_override` = 1, `active_sel` equals `reg_sel` in the same cycle, with no register stage in between.
- R7: `spread_en` is 1 exactly for active codes 01100 to 01111, 11100 to 11111, 00001, 10011 and 10101 (binary, bit 4 first). For every other code it is 0.
- R8: `sio_24m` is 1 when `pin_lvl[5]` was captured high, which selects a 24 MHz super I/O clock. It is 0 when that strap was captured low, which selects 48 MHz.
- R9: While `test_hiz` is 1, `pin_oe` is all zeros and `clk_drive_en` is 0. Clearing `test_hiz` after expiry restores the drivers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| pin_lvl | input | 6 | Levels seen on the shared pins; bits 4:0 are the select straps, bit 5 is the super I/O strap |
| sel_override | input | 1 | 1 selects `reg_sel` instead of the strapped code |
| reg_sel | input | 5 | Register-supplied frequency select code |
| test_hiz | input | 1 | Test mode: three-state all clock outputs |
| pin_oe | output | 6 | Per-pin output enable for the shared pins |
| clk_drive_en | output | 1 | Enable for all other clock drivers |
| active_sel | output | 5 | Frequency select code in effect |
| spread_en | output | 1 | Spread spectrum is active for the selected code |
| sio_24m | output | 1 | 1 = super I/O clock at 24 MHz, 0 = 48 MHz |

## Verification
The hardest case to reach is a change of pin level exactly at the final timer edge. Reaching it requires stimulus aligned with the turnaround cycle.

The bench drives a known value until a few cycles before expiry. It then changes the value on the cycle before the last sampling edge, so that only that last value should survive. It then toggles the pins again right after expiry to show that the capture is frozen.

A second reset with different straps shows that capture happens once per reset. A full sweep of `reg_sel` under override covers every spread-spectrum code.

// File: rtl/strp_pkg.sv
package strp_pkg;
  localparam int SEL_W = 5;
  localparam int PIN_N = SEL_W + 1;

  typedef logic [SEL_W-1:0] sel_t;

  // Spread-spectrum decode of the 5-bit select code.
  function automatic logic spread_for(input sel_t code);
    logic r;
    casez (code)
      5'b?11??: r = 1'b1;   // 01100..01111 and 11100..11111
      5'b00001: r = 1'b1;
      5'b10011: r = 1'b1;
      5'b10101: r = 1'b1;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/strp_timer.sv
module strp_timer #(
  parameter int CYCLES = 400000
) (
  input  logic clk,
  input  logic rst_n,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == CW'(CYCLES));

  // R2: once expired, the timer stays expired until reset
  assert_expiry_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> expired);

  // R2: the count advances by one per cycle before expiry
  assert_count_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !expired |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/strp_hold.sv
module strp_hold #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (sample_en) q <= d;
  end

  // R3: the capture is frozen once sampling stops
  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(q));
endmodule

// File: rtl/strp_select.sv
module strp_select
  import strp_pkg::*;
(
  input  sel_t strap_sel,
  input  logic override,
  input  sel_t reg_sel,
  output sel_t active_sel,
  output logic spread_en
);
  assign active_sel = override ? reg_sel : strap_sel;
  assign spread_en  = spread_for(active_sel);
endmodule

// File: rtl/strap_turnaround.sv
module strap_turnaround
  import strp_pkg::*;
#(
  parameter int TURN_CYCLES = 400000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_N-1:0] pin_lvl,
  input  logic             sel_override,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             test_hiz,
  output logic [PIN_N-1:0] pin_oe,
  output logic             clk_drive_en,
  output logic [SEL_W-1:0] active_sel,
  output logic             spread_en,
  output logic             sio_24m
);
  localparam int SIO_BIT = SEL_W;

  logic             tmr_expired;
  logic [PIN_N-1:0] strap_word;

  strp_timer #(.CYCLES(TURN_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .expired (tmr_expired)
  );

  strp_hold #(.W(PIN_N)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (!tmr_expired),
    .d         (pin_lvl),
    .q         (strap_word)
  );

  strp_select u_sel (
    .strap_sel  (strap_word[SEL_W-1:0]),
    .override   (sel_override),
    .reg_sel    (reg_sel),
    .active_sel (active_sel),
    .spread_en  (spread_en)
  );

  assign clk_drive_en = tmr_expired && !test_hiz;
  assign sio_24m      = strap_word[SIO_BIT];

  for (genvar i = 0; i < PIN_N; i++) begin : g_oe
    assign pin_oe[i] = clk_drive_en;
  end

  // R1: no pin is driven before the timer expires
  assert_no_drive_early_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_expired |-> (pin_oe == '0));

  // R9: test mode keeps every driver off
  assert_hiz_test_R9: assert property (@(posedge clk) disable iff (!rst_n)
    test_hiz |-> (pin_oe == '0 && !clk_drive_en));

  // R2: after expiry without test mode, all pins are driven
  assert_drive_after_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_expired && !test_hiz) |-> (pin_oe == '1));

  // R7: a spread-spectrum code chosen by register raises spread_en
  assert_spread_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_override && reg_sel == 5'b10011) |-> spread_en);

  // R3: after expiry the strap-derived outputs hold while override is steady
  assert_strap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_expired && !sel_override) |=> (!sel_override -> $stable(active_sel)) && $stable(sio_24m));
endmodule

// File: tb/strap_turnaround_bench.sv
`timescale 1ns/1ps
module strap_turnaround_bench;
  localparam int N = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] pin_lvl = 6'd0;
  logic       sel_override = 1'b0;
  logic [4:0] reg_sel = 5'd0;
  logic       test_hiz = 1'b0;
  logic [5:0] pin_oe;
  logic       clk_drive_en;
  logic [4:0] active_sel;
  logic       spread_en;
  logic       sio_24m;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  // behavioural reference state
  int         m_cycles = 0;
  logic [5:0] m_capture = 6'd0;

  always #2.5 clk = ~clk;

  strap_turnaround #(.TURN_CYCLES(N)) u_strap_turnaround (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .sel_override(sel_override),
    .reg_sel(reg_sel), .test_hiz(test_hiz), .pin_oe(pin_oe),
    .clk_drive_en(clk_drive_en), .active_sel(active_sel),
    .spread_en(spread_en), .sio_24m(sio_24m)
  );

  // Reference: count edges since reset, sample straps while counting.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cycles  = 0;
      m_capture = 6'd0;
    end else if (m_cycles < N) begin
      m_capture = pin_lvl;
      m_cycles  = m_cycles + 1;
    end
  end

  function automatic bit ref_spread(input int c);
    return (c >= 12 && c <= 15) || (c >= 28 && c <= 31) || c == 1 || c == 19 || c == 21;
  endfunction

  task automatic cmp(input string what, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  // Compare every cycle at the falling edge, before new stimulus.
  task automatic step();
    int  sel_exp;
    bit  drive;
    @(negedge clk);
    drive   = rst_n && (m_cycles >= N) && !test_hiz;
    sel_exp = sel_override ? int'(reg_sel) : int'(m_capture[4:0]);
    cmp("pin_oe", pin_oe, drive ? 63 : 0);             // R1 R2 R9
    cmp("clk_drive_en", clk_drive_en, drive);
    cmp("active_sel", active_sel, sel_exp);            // R5 R6
    cmp("spread_en", spread_en, ref_spread(sel_exp));  // R7
    cmp("sio_24m", sio_24m, m_capture[5]);             // R8 R3 R4
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got no completion expected finish");
    summary();
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    pin_lvl = 6'b100000;
    repeat (3) step();
    rst_n = 1'b1;
    // R1/R3: pins wander during the timer window
    for (int i = 0; i < N - 3; i++) begin
      pin_lvl = 6'(i);
      step();
    end
    // R3: value present before the final sampling edge must win
    cur_req = "R3";
    pin_lvl = 6'b001111;
    step();
    pin_lvl = 6'b101101;   // sio high, code 01101
    step();
    cur_req = "R2";
    step();
    step();
    // R3: post-expiry pin changes are ignored; R5/R7/R8 on strapped code
    cur_req = "R3";
    for (int i = 0; i < 8; i++) begin
      pin_lvl = 6'(i * 9);
      step();
    end
    cur_req = "R5";
    repeat (3) step();
    // R6/R7: override sweep over all codes
    cur_req = "R6";
    sel_override = 1'b1;
    for (int c = 0; c < 32; c++) begin
      reg_sel = 5'(c);
      step();
    end
    cur_req = "R7";
    reg_sel = 5'b10101; step();
    reg_sel = 5'b10110; step();
    sel_override = 1'b0;
    step();
    // R9: test mode on and off
    cur_req = "R9";
    test_hiz = 1'b1;
    repeat (4) step();
    test_hiz = 1'b0;
    repeat (2) step();
    // R4: second reset recaptures, sio low (R8), code 00010 (no spread)
    cur_req = "R4";
    rst_n = 1'b0;
    pin_lvl = 6'b000010;
    repeat (2) step();
    rst_n = 1'b1;
    repeat (N + 4) step();
    cur_req = "R8";
    pin_lvl = 6'b111111;
    repeat (3) step();
    summary();
  end
endmodule